// File: doc/BRIEF.md
# Coarse Full-Circle Vector Angle Estimator

This block turns a signed two-component vector into an approximate angle over the whole circle, without a divider. Each input vector is first folded into the first quadrant. The sign bits are kept aside, and each component is replaced by its magnitude. Both magnitudes are then shifted left by one common amount until the larger of the two reaches the top bit. The leading bits of each magnitude form the row and column of a square grid that covers one quadrant.

A table built at elaboration time holds, for every grid cell, the angle of that cell's centre. The looked-up angle is then moved back into the quadrant given by the saved signs. The result is an unsigned phase word in which the full word range equals one turn.

The block suits phase and frequency tracking, where a coarse angle per sample is enough. It accepts one vector per clock and returns each answer a fixed number of clocks later.

Top module: `coarse_atan2`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly three clocks. One result is produced for each accepted vector, including vectors on consecutive clocks. A low `rst_n` at a clock edge discards every vector in flight, and `out_valid` is low after that edge.
- R2: The magnitudes are shifted by a common amount until the larger one has bit 14 set. The cell row is then bits 14 to 10 of the shifted |y|, and the cell column is bits 14 to 10 of the shifted |x|. The output, taken modulo 4096, differs from the true four-quadrant angle of (x, y) in 4096-per-turn units by no more than the largest angle between the cell centre and any cell corner, plus one unit.
- R3: A component that is zero counts as non-negative. Let t be the first-quadrant result for (|x|, |y|). The output is then t when x >= 0 and y >= 0; 2048 - t when x < 0 and y >= 0; 2048 + t when both are negative; and 4096 - t when x >= 0 and y < 0. All results are reduced modulo 4096.
- R4: The vector (0, 0) yields phase 0.
- R5: The code -32768 in either component behaves exactly as +32767 in magnitude, with its sign kept as negative.
- R6: Multiplying both components by the same power of two, without overflow, leaves the output unchanged.
- R7: A non-zero vector with |x| = |y| yields exactly 512, 1536, 2560 or 3584 for the first, second, third and fourth quadrant respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks a vector on `in_x`/`in_y` this clock |
| in_x | input | 16 | Horizontal component, two's complement |
| in_y | input | 16 | Vertical component, two's complement |
| out_valid | output | 1 | Marks a result on `out_phase` |
| out_phase | output | 12 | Angle, 4096 units per turn, counter-clockwise from +x |

## Verification
A synchronous reset can coincide with a vector being presented and with older vectors still moving through the three stages. In that case reset must win, and every one of those vectors must vanish without a trace. The bench asserts reset for two clocks in the middle of a back-to-back stream while `in_valid` stays high. Its per-clock reference pipeline drops the same entries, and `out_valid` is compared on every clock before, during and after the reset. A second coincidence happens inside one result: the quadrant move and the centre-angle lookup combine. The bench judges this with mirrored vector sets whose outputs must obey the exact quadrant relations.

// File: rtl/atan_grid_pkg.sv
`timescale 1ns/1ps
// Shared types and elaboration-time helpers for the grid angle estimator.
// Assumes the phase word is at most 20 bits wide.
package atan_grid_pkg;

    typedef enum logic [1:0] {
        QUAD_I   = 2'd0,
        QUAD_II  = 2'd1,
        QUAD_III = 2'd2,
        QUAD_IV  = 2'd3
    } quad_e;

    localparam int ROT_STEPS = 16;   // rotation iterations used to fill the table
    localparam int TURN_BITS = 20;   // internal angle resolution, units per turn = 2**20

    // Angle of the k-th elementary rotation, atan(2**-k), in 2**20-per-turn units.
    function automatic longint rot_angle(input int k);
        case (k)
            0:  return 131072;
            1:  return 77376;
            2:  return 40884;
            3:  return 20753;
            4:  return 10417;
            5:  return 5213;
            6:  return 2607;
            7:  return 1304;
            8:  return 652;
            9:  return 326;
            10: return 163;
            11: return 81;
            12: return 41;
            13: return 20;
            14: return 10;
            15: return 5;
            default: return 0;
        endcase
    endfunction

    // Angle of the centre of grid cell (col, row) in first-quadrant phase units.
    function automatic int cell_angle(input int col, input int row, input int ph_w);
        longint px;
        longint py;
        longint acc;
        longint dx;
        longint dy;
        px  = longint'(2 * col + 1) <<< 16;
        py  = longint'(2 * row + 1) <<< 16;
        acc = 0;
        for (int k = 0; k < ROT_STEPS; k++) begin
            dx = px >>> k;
            dy = py >>> k;
            if (py > 0) begin
                px  = px + dy;
                py  = py - dx;
                acc = acc + rot_angle(k);
            end else begin
                px  = px - dy;
                py  = py + dx;
                acc = acc - rot_angle(k);
            end
        end
        return int'((acc + (longint'(1) <<< (TURN_BITS - ph_w - 1))) >>> (TURN_BITS - ph_w));
    endfunction

endpackage

// File: rtl/atan_fold_norm.sv
`timescale 1ns/1ps
// Stage 1: folds the vector into the first quadrant and normalises it.
// Takes saturated magnitudes, records the quadrant from the two sign bits,
// shifts both magnitudes left by a common amount until the larger one
// reaches the top magnitude bit, and registers the leading bits as a grid cell.
// Assumes IN_W - 1 >= CELL_BITS.
module atan_fold_norm
    import atan_grid_pkg::*;
#(
    parameter int IN_W      = 16,
    parameter int CELL_BITS = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic signed [IN_W-1:0] in_x,
    input  logic signed [IN_W-1:0] in_y,
    output logic                  out_valid,
    output quad_e                 out_quad,
    output logic                  out_zero,
    output logic [CELL_BITS-1:0]  out_col,
    output logic [CELL_BITS-1:0]  out_row
);

    localparam int MAG_W = IN_W - 1;
    localparam int SH_W  = $clog2(MAG_W);
    localparam int SKIP  = MAG_W - CELL_BITS;
    localparam logic signed [IN_W-1:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};

    logic [MAG_W-1:0] mag_x, mag_y, spread, norm_x, norm_y;
    logic [SH_W-1:0]  shamt;
    quad_e            quad_c;

    // Magnitude with the most negative code clamped to the largest positive one.
    function automatic logic [MAG_W-1:0] sat_abs(input logic signed [IN_W-1:0] v);
        logic signed [IN_W-1:0] neg;
        neg = -v;
        if (!v[IN_W-1])
            return v[MAG_W-1:0];
        else if (v == MOST_NEG)
            return {MAG_W{1'b1}};
        else
            return neg[MAG_W-1:0];
    endfunction

    // Fold both components to magnitudes.
    always_comb begin
        mag_x  = sat_abs(in_x);
        mag_y  = sat_abs(in_y);
        spread = mag_x | mag_y;
    end

    // Common shift: distance of the highest set bit of either magnitude from the top.
    always_comb begin
        shamt = '0;
        for (int i = 0; i < MAG_W; i++) begin
            if (spread[i])
                shamt = SH_W'(MAG_W - 1 - i);
        end
    end

    // Normalised magnitudes.
    always_comb begin
        norm_x = mag_x << shamt;
        norm_y = mag_y << shamt;
    end

    // Quadrant from the sign bits; zero counts as non-negative.
    always_comb begin
        unique case ({in_y[IN_W-1], in_x[IN_W-1]})
            2'b00:   quad_c = QUAD_I;
            2'b01:   quad_c = QUAD_II;
            2'b11:   quad_c = QUAD_III;
            default: quad_c = QUAD_IV;
        endcase
    end

    // Valid flag of stage 1.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Cell address, quadrant and zero flag of stage 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_quad <= QUAD_I;
            out_zero <= 1'b0;
            out_col  <= '0;
            out_row  <= '0;
        end else if (in_valid) begin
            out_quad <= quad_c;
            out_zero <= (spread == '0);
            out_col  <= CELL_BITS'(norm_x >> SKIP);
            out_row  <= CELL_BITS'(norm_y >> SKIP);
        end
    end

    // R2
    norm_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_zero |-> (out_col[CELL_BITS-1] || out_row[CELL_BITS-1]));

    // R4
    zero_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_zero |-> (out_col == '0 && out_row == '0));

    // R5
    most_neg_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_x == MOST_NEG && in_y == '0 |=> out_col == '1 && out_row == '0 && out_quad == QUAD_II);

endmodule

// File: rtl/atan_cell_rom.sv
`timescale 1ns/1ps
// Stage 2: reads the first-quadrant angle of the addressed grid cell.
// The table holds the angle of each cell centre and is computed at
// elaboration time; a zero vector reads as angle 0.
// Assumes PH_W >= 3 and PH_W <= 20.
module atan_cell_rom
    import atan_grid_pkg::*;
#(
    parameter int CELL_BITS = 5,
    parameter int PH_W      = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  quad_e                in_quad,
    input  logic                 in_zero,
    input  logic [CELL_BITS-1:0] in_col,
    input  logic [CELL_BITS-1:0] in_row,
    output logic                 out_valid,
    output quad_e                out_quad,
    output logic [PH_W-1:0]      out_theta
);

    localparam int GRID  = 1 << CELL_BITS;
    localparam int DEPTH = GRID * GRID;
    localparam logic [PH_W-1:0] QTR  = PH_W'(1 << (PH_W - 2));
    localparam logic [PH_W-1:0] OCTA = PH_W'(1 << (PH_W - 3));

    logic [PH_W-1:0] centre_tab [DEPTH];

    // One constant entry per cell, addressed as {row, col}.
    for (genvar gr = 0; gr < GRID; gr++) begin : g_row
        for (genvar gc = 0; gc < GRID; gc++) begin : g_col
            assign centre_tab[gr * GRID + gc] = PH_W'(cell_angle(gc, gr, PH_W));
        end
    end

    // Valid flag of stage 2.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Registered table read with the zero override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_quad  <= QUAD_I;
            out_theta <= '0;
        end else if (in_valid) begin
            out_quad  <= in_quad;
            out_theta <= in_zero ? '0 : centre_tab[{in_row, in_col}];
        end
    end

    // R2
    theta_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_theta <= QTR);

    // R4
    zero_theta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_zero |=> out_theta == '0);

    // R7
    diagonal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_zero && in_col == in_row |=> out_theta == OCTA);

endmodule

// File: rtl/atan_quad_map.sv
`timescale 1ns/1ps
// Stage 3: moves the first-quadrant angle into the quadrant of the input.
// Arithmetic wraps in PH_W bits, so results are modulo one turn.
// Assumes the incoming angle lies between 0 and a quarter turn.
module atan_quad_map
    import atan_grid_pkg::*;
#(
    parameter int PH_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  quad_e           in_quad,
    input  logic [PH_W-1:0] in_theta,
    output logic            out_valid,
    output logic [PH_W-1:0] out_phase
);

    localparam logic [PH_W-1:0] HALF = PH_W'(1 << (PH_W - 1));
    localparam logic [PH_W-1:0] QTR  = PH_W'(1 << (PH_W - 2));

    logic [PH_W-1:0] mapped;

    // Reflection or rotation per quadrant.
    always_comb begin
        unique case (in_quad)
            QUAD_I:   mapped = in_theta;
            QUAD_II:  mapped = HALF - in_theta;
            QUAD_III: mapped = HALF + in_theta;
            default:  mapped = '0 - in_theta;
        endcase
    end

    // Valid flag of stage 3.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Output phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_phase <= '0;
        else if (in_valid) out_phase <= mapped;
    end

    // R3
    quad2_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_quad == QUAD_II |=> out_phase >= QTR && out_phase <= HALF);

    // R3
    quad3_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_quad == QUAD_III |=> out_phase >= HALF && out_phase <= HALF + QTR);

    // R3
    quad4_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_quad == QUAD_IV && in_theta != '0 |=> out_phase >= HALF + QTR);

endmodule

// File: rtl/coarse_atan2.sv
`timescale 1ns/1ps
// Top: division-free coarse angle of a signed vector over the full circle.
// Three registered stages: fold and normalise, cell table read, quadrant map.
// Accepts one vector per clock; results appear three clocks later.
module coarse_atan2
    import atan_grid_pkg::*;
#(
    parameter int IN_W      = 16,
    parameter int CELL_BITS = 5,
    parameter int PH_W      = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_x,
    input  logic signed [IN_W-1:0] in_y,
    output logic                   out_valid,
    output logic [PH_W-1:0]        out_phase
);

    logic                 s1_valid, s1_zero, s2_valid;
    quad_e                s1_quad, s2_quad;
    logic [CELL_BITS-1:0] s1_col, s1_row;
    logic [PH_W-1:0]      s2_theta;

    atan_fold_norm #(.IN_W(IN_W), .CELL_BITS(CELL_BITS)) u_fold (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .out_valid(s1_valid), .out_quad(s1_quad), .out_zero(s1_zero),
        .out_col(s1_col), .out_row(s1_row)
    );

    atan_cell_rom #(.CELL_BITS(CELL_BITS), .PH_W(PH_W)) u_rom (
        .clk(clk), .rst_n(rst_n), .in_valid(s1_valid), .in_quad(s1_quad),
        .in_zero(s1_zero), .in_col(s1_col), .in_row(s1_row),
        .out_valid(s2_valid), .out_quad(s2_quad), .out_theta(s2_theta)
    );

    atan_quad_map #(.PH_W(PH_W)) u_map (
        .clk(clk), .rst_n(rst_n), .in_valid(s2_valid), .in_quad(s2_quad),
        .in_theta(s2_theta), .out_valid(out_valid), .out_phase(out_phase)
    );

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3));

endmodule

// File: tb/tb_coarse_atan2.sv
`timescale 1ns/1ps
module tb_coarse_atan2;

    localparam real PI = 3.14159265358979;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_x = '0;
    logic signed [15:0] in_y = '0;
    logic               out_valid;
    logic [11:0]        out_phase;

    always #2.5 clk = ~clk;

    coarse_atan2 dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .out_valid(out_valid), .out_phase(out_phase)
    );

    typedef struct { bit v; int x; int y; int id; } item_t;
    item_t pipe [3];
    int    res  [256];
    bit    got  [256];
    int    errors = 0;
    int    checks = 0;
    int    next_id = 0;
    bit    done = 0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sabs(input int v);
        if (v == -32768) return 32767;
        return (v < 0) ? -v : v;
    endfunction

    function automatic real true_phase(input int x, input int y);
        real a;
        a = $atan2(real'(y), real'(x));
        if (a < 0.0) a = a + 2.0 * PI;
        return a * 4096.0 / (2.0 * PI);
    endfunction

    // Allowed error: widest angle from the cell centre to a cell corner, plus one unit.
    function automatic real tol_of(input int x, input int y);
        int ax, ay, m, sh, col, row;
        real c, w, d;
        ax = sabs(x); ay = sabs(y);
        m = (ax > ay) ? ax : ay;
        sh = 0;
        while (m < 16384) begin m = m * 2; sh++; end
        col = (ax << sh) >> 10;
        row = (ay << sh) >> 10;
        c = $atan2(real'(row) + 0.5, real'(col) + 0.5);
        w = 0.0;
        for (int dr = 0; dr < 2; dr++) begin
            for (int dc = 0; dc < 2; dc++) begin
                d = $atan2(real'(row + dr), real'(col + dc)) - c;
                if (d < 0.0) d = -d;
                if (d > w) w = d;
            end
        end
        return w * 4096.0 / (2.0 * PI) + 1.0;
    endfunction

    task automatic judge(input item_t it, input int ph);
        int ax, ay, q;
        real d, t;
        if (it.id >= 0) begin res[it.id] = ph; got[it.id] = 1'b1; end
        ax = sabs(it.x); ay = sabs(it.y);
        if (ax == 0 && ay == 0) begin
            check(ph == 0, "R4", "zero vector phase", ph, 0);
        end else begin
            if (ax == ay) begin
                q = (it.y < 0) ? ((it.x < 0) ? 2560 : 3584) : ((it.x < 0) ? 1536 : 512);
                check(ph == q, "R7", "diagonal phase", ph, q);
            end
            d = real'(ph) - true_phase(it.x, it.y);
            while (d > 2048.0)  d = d - 4096.0;
            while (d < -2048.0) d = d + 4096.0;
            if (d < 0.0) d = -d;
            t = tol_of(it.x, it.y);
            check(d <= t, "R2", "phase error bound", ph, int'(true_phase(it.x, it.y)) % 4096);
        end
    endtask

    // One clock: compare outputs against the reference pipeline, then drive.
    task automatic step(input bit v, input int x, input int y, input bit r, input int id);
        @(negedge clk);
        check(out_valid === pipe[2].v, "R1", "out_valid", int'(out_valid), int'(pipe[2].v));
        if (pipe[2].v && out_valid === 1'b1) judge(pipe[2], int'(out_phase));
        pipe[2] = pipe[1];
        pipe[1] = pipe[0];
        rst_n    = r;
        in_valid = v;
        in_x     = 16'(x);
        in_y     = 16'(y);
        pipe[0].v  = v && r;
        pipe[0].x  = x;
        pipe[0].y  = y;
        pipe[0].id = id;
        if (!r) begin pipe[1].v = 1'b0; pipe[2].v = 1'b0; end
    endtask

    task automatic send(input int x, input int y, output int id);
        id = next_id;
        next_id++;
        step(1'b1, x, y, 1'b1, id);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b1, -1);
    endtask

    task automatic rel(input string req, input string what, input int id, input int exp);
        int e;
        e = ((exp % 4096) + 4096) % 4096;
        check(got[id] && res[id] == e, req, what, res[id], e);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int a1, a2, a3, a4, b1, b2, b3, b4, c1, c2, c3, c4;
        int z1, z2, z3, z4, s1, s2, s3, s4, s5, s6, k1, k2, k3, k4, zz;
        for (int i = 0; i < 3; i++) begin pipe[i].v = 1'b0; pipe[i].x = 0; pipe[i].y = 0; pipe[i].id = -1; end
        for (int i = 0; i < 256; i++) begin res[i] = -1; got[i] = 1'b0; end

        // R1: reset state, out_valid must stay low
        for (int i = 0; i < 4; i++) step(1'b0, 0, 0, 1'b0, -1);
        idle(3);

        // R4: zero vector
        send(0, 0, zz);

        // R3: four mirrored copies of three base vectors, back to back
        send(12000, 3000, a1); send(-12000, 3000, a2); send(-12000, -3000, a3); send(12000, -3000, a4);
        send(5, 9000, b1);     send(-5, 9000, b2);     send(-5, -9000, b3);     send(5, -9000, b4);
        send(321, 320, c1);    send(-321, 320, c2);    send(-321, -320, c3);    send(321, -320, c4);

        // R3: axis vectors, zero counts as non-negative
        send(900, 0, z1); send(-900, 0, z2); send(0, 77, z3); send(0, -77, z4);

        // R5: most negative code
        send(-32768, 1000, s1);   send(-32767, 1000, s2);
        send(-32768, -32768, s3); send(-32767, -32767, s4);
        send(4, -32768, s5);      send(4, -32767, s6);

        // R6: common power-of-two scaling
        send(300, 50, k1); idle(1); send(300 * 64, 50 * 64, k2);
        send(-3, 11, k3);  idle(2); send(-3 * 2048, 11 * 2048, k4);

        // R7: diagonals
        step(1'b1, 1000, 1000, 1'b1, -1);
        step(1'b1, -7, -7, 1'b1, -1);
        step(1'b1, -32768, 32767, 1'b1, -1);
        step(1'b1, 1, -1, 1'b1, -1);
        idle(4);

        // R1: reset in the middle of a back-to-back stream with in_valid held high
        step(1'b1, 100, 200, 1'b1, -1);
        step(1'b1, -100, 200, 1'b1, -1);
        step(1'b1, 100, -200, 1'b0, -1);
        step(1'b1, 300, 20, 1'b0, -1);
        step(1'b1, -300, -20, 1'b1, -1);
        step(1'b1, 7, 7000, 1'b1, -1);
        idle(5);

        // R2, R1: random vectors over all quadrants and scales, random gaps
        for (int n = 0; n < 1500; n++) begin
            logic signed [15:0] rx, ry;
            int sh;
            rx = 16'($urandom);
            ry = 16'($urandom);
            sh = int'($urandom % 14);
            step(($urandom % 4) != 0, int'(rx) >>> sh, int'(ry) >>> sh, 1'b1, -1);
        end
        idle(5);

        rel("R3", "quadrant II of base A",  a2, 2048 - res[a1]);
        rel("R3", "quadrant III of base A", a3, 2048 + res[a1]);
        rel("R3", "quadrant IV of base A",  a4, 4096 - res[a1]);
        rel("R3", "quadrant II of base B",  b2, 2048 - res[b1]);
        rel("R3", "quadrant III of base B", b3, 2048 + res[b1]);
        rel("R3", "quadrant IV of base B",  b4, 4096 - res[b1]);
        rel("R3", "quadrant II of base C",  c2, 2048 - res[c1]);
        rel("R3", "quadrant III of base C", c3, 2048 + res[c1]);
        rel("R3", "quadrant IV of base C",  c4, 4096 - res[c1]);
        rel("R3", "negative x on the x axis", z2, 2048 - res[z1]);
        rel("R3", "negative y on the y axis", z4, 4096 - res[z3]);
        rel("R4", "zero vector", zz, 0);
        rel("R5", "-32768 in x", s1, res[s2]);
        rel("R5", "-32768 in both", s3, res[s4]);
        rel("R5", "-32768 in y", s5, res[s6]);
        rel("R6", "scaled by 64", k2, res[k1]);
        rel("R6", "scaled by 2048", k4, res[k3]);

        summary();
        $finish;
    end

endmodule